// File: doc/BRIEF.md
# Modular-Exponentiation Engine Control Registers

This block is the register front end of a public-key modular-exponentiation accelerator. Host software reaches it over a simple 32-bit register bus with a select, a write strobe, an address and write data. The read data returns in the same cycle. Software programs where the operand image sits in memory, how many bytes the loader must fetch, and the bit lengths of the exponent and the modulus. It also chooses whether the operand memory belongs to the host bus or to the engine. It then sets two start bits with a single write.

The block turns each rising start bit into a one-cycle pulse: one pulse goes to the DMA loader and one to the arithmetic core. The core may run only while its start bit stays set. When the core reports completion with a done pulse, the block latches it in a status bit. Software clears that bit by writing a one to it. A mask bit decides whether the latched status drives the level interrupt. The usual handler reads the status, writes it back to clear it, and writes zero to the start register to stop the engine.

Top module: `modexp_ctrl_regs`

## Requirements
- R1: After reset every register reads zero except the operand command register at 0x048, which reads 0x0000_0100 (host owns the operand memory). After reset both start pulses, the run level and the interrupt are low.
- R2: The source base at 0x04C and the length at 0x050 read back the full 32-bit value last written and drive it on their outputs. The bit-length register at 0x058 also reads back its full value, and it drives the exponent bit count from bits [31:16] and the modulus bit count from bits [15:0].
- R3: In the start register at 0x000, bit 0 is the core start and bit 1 is the loader start; the register reads back these two bits. Each bit that goes from 0 to 1 produces a pulse on its own start output for exactly one cycle, the cycle after the write. A write that leaves a bit at 1 produces no pulse for that bit.
- R4: The core run output follows bit 0 of the start register, so writing zero to 0x000 stops the core in the cycle after the write.
- R5: In the command register at 0x048, bits [5:4] = 2'b11 select the RSA operand mode output, and bit 8 set gives the operand memory to the host bus (bit 8 clear gives it to the engine). All other bits read as zero.
- R6: A done pulse sets status bit 1 at 0x3FC (reads 0x0000_0002). The bit stays set until a write to 0x3FC with bit 1 set. A write with bit 1 clear leaves it set.
- R7: A done pulse in the same cycle as a clearing write to 0x3FC leaves status bit 1 set.
- R8: The interrupt output equals status bit 1 AND mask bit 1 at 0x3F8. The mask register reads back only bit 1.
- R9: Reads of offsets outside the seven mapped ones return zero, and writes to them change no mapped register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle; zero when not reading |
| core_done | input | 1 | Completion pulse from the arithmetic core |
| dma_start | output | 1 | One-cycle start pulse to the operand loader |
| core_start | output | 1 | One-cycle start pulse to the arithmetic core |
| core_run | output | 1 | Core may run while high |
| operand_mode_rsa | output | 1 | RSA operand-memory mode selected |
| operand_host_own | output | 1 | 1 = host bus owns operand memory, 0 = engine |
| dma_src_base | output | 32 | Loader source base address |
| dma_byte_len | output | 32 | Loader transfer length |
| exp_bit_len | output | 16 | Exponent bit count |
| mod_bit_len | output | 16 | Modulus bit count |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume that the done input comes from a core that has been started. They assume it is a short pulse, and that the select, write and address inputs change only between clock edges. The bench keeps to this. Its stub core raises done only while the run level is high, after a programmable count, for one cycle. The only extra done pulses the bench drives are single-cycle pulses, which it uses to test the masking and the collision with a clearing write. All bus inputs are driven on the falling edge.

// File: rtl/modexp_ctrl_pkg.sv
// Shared constants for the modular-exponentiation control registers.
// Assumes byte offsets of at least 12 bits; only offsets and bit positions
// that software or neighbouring logic decode are fixed here.
package modexp_ctrl_pkg;

    localparam logic [11:0] OFS_START = 12'h000;
    localparam logic [11:0] OFS_CMD   = 12'h048;
    localparam logic [11:0] OFS_SRC   = 12'h04C;
    localparam logic [11:0] OFS_LEN   = 12'h050;
    localparam logic [11:0] OFS_BITS  = 12'h058;
    localparam logic [11:0] OFS_MASK  = 12'h3F8;
    localparam logic [11:0] OFS_STAT  = 12'h3FC;

    localparam int START_CORE  = 0;
    localparam int START_DMA   = 1;
    localparam int START_W     = 2;
    localparam int CMD_MODE_LO = 4;
    localparam int CMD_HOST    = 8;
    localparam int DONE_POS    = 1;

    localparam logic [1:0] MODE_RSA = 2'b11;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_START,
        RS_CMD,
        RS_SRC,
        RS_LEN,
        RS_BITS,
        RS_MASK,
        RS_STAT
    } reg_sel_e;

endpackage

// File: rtl/modexp_cfg_regs.sv
// Configuration register storage, address decode and read mux.
// Assumes one access per cycle; read data is combinational from the address.
// Only implemented bits are stored; the rest read as zero.
module modexp_cfg_regs
    import modexp_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                done_flag,
    output logic [START_W-1:0]  start_q,
    output logic [1:0]          mode_q,
    output logic                host_q,
    output logic [DATA_W-1:0]   src_q,
    output logic [DATA_W-1:0]   len_q,
    output logic [DATA_W-1:0]   bits_q,
    output logic                mask_q,
    output logic                stat_clr,
    output logic [DATA_W-1:0]   rdata
);

    reg_sel_e sel;

    // Decode the byte offset into a register select.
    always_comb begin
        if      (addr == ADDR_W'(OFS_START)) sel = RS_START;
        else if (addr == ADDR_W'(OFS_CMD))   sel = RS_CMD;
        else if (addr == ADDR_W'(OFS_SRC))   sel = RS_SRC;
        else if (addr == ADDR_W'(OFS_LEN))   sel = RS_LEN;
        else if (addr == ADDR_W'(OFS_BITS))  sel = RS_BITS;
        else if (addr == ADDR_W'(OFS_MASK))  sel = RS_MASK;
        else if (addr == ADDR_W'(OFS_STAT))  sel = RS_STAT;
        else                                 sel = RS_NONE;
    end

    // Write-one-to-clear request for the done status bit.
    assign stat_clr = wr_en && (sel == RS_STAT) && wdata[DONE_POS];

    // Register writes; ownership resets to the host bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            mode_q  <= '0;
            host_q  <= 1'b1;
            src_q   <= '0;
            len_q   <= '0;
            bits_q  <= '0;
            mask_q  <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                RS_START: start_q <= wdata[START_W-1:0];
                RS_CMD: begin
                    mode_q <= wdata[CMD_MODE_LO +: 2];
                    host_q <= wdata[CMD_HOST];
                end
                RS_SRC:  src_q  <= wdata;
                RS_LEN:  len_q  <= wdata;
                RS_BITS: bits_q <= wdata;
                RS_MASK: mask_q <= wdata[DONE_POS];
                default: ;
            endcase
        end
    end

    // Read mux; unmapped offsets and idle cycles return zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                RS_START: rdata[START_W-1:0] = start_q;
                RS_CMD: begin
                    rdata[CMD_MODE_LO +: 2] = mode_q;
                    rdata[CMD_HOST]         = host_q;
                end
                RS_SRC:  rdata = src_q;
                RS_LEN:  rdata = len_q;
                RS_BITS: rdata = bits_q;
                RS_MASK: rdata[DONE_POS] = mask_q;
                RS_STAT: rdata[DONE_POS] = done_flag;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/modexp_start_edge.sv
// Rising-edge detector for the start bits: one pulse per 0-to-1 change.
// Assumes the level inputs are registers in the same clock domain.
module modexp_start_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] pulse
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_q;

        // Remember last cycle's level of this start bit.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl[i];
        end

        assign pulse[i] = lvl[i] & ~prev_q;
    end

endmodule

// File: rtl/modexp_done_irq.sv
// Latches the core's done pulse and forms the masked level interrupt.
// Assumes done is a pulse; a set in the same cycle as a clear wins.
module modexp_done_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done_in,
    input  logic clr,
    input  logic mask_en,
    output logic done_flag,
    output logic irq
);

    // Sticky completion status, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) done_flag <= 1'b0;
        else        done_flag <= done_in | (done_flag & ~clr);
    end

    assign irq = done_flag & mask_en;

endmodule

// File: rtl/modexp_ctrl_regs.sv
// Top of the modular-exponentiation control register block.
// Assumes a single-master register bus with same-cycle read data and
// a done pulse from a core that was started by core_start.
module modexp_ctrl_regs
    import modexp_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              core_done,
    output logic              dma_start,
    output logic              core_start,
    output logic              core_run,
    output logic              operand_mode_rsa,
    output logic              operand_host_own,
    output logic [DATA_W-1:0] dma_src_base,
    output logic [DATA_W-1:0] dma_byte_len,
    output logic [DATA_W/2-1:0] exp_bit_len,
    output logic [DATA_W/2-1:0] mod_bit_len,
    output logic              irq
);

    localparam int HALF_W = DATA_W / 2;

    logic               wr_en;
    logic               rd_en;
    logic [START_W-1:0] start_q;
    logic [START_W-1:0] start_pulse;
    logic [1:0]         mode_q;
    logic [DATA_W-1:0]  bits_q;
    logic               mask_q;
    logic               stat_clr;
    logic               done_flag;

    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    modexp_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .done_flag (done_flag),
        .start_q   (start_q),
        .mode_q    (mode_q),
        .host_q    (operand_host_own),
        .src_q     (dma_src_base),
        .len_q     (dma_byte_len),
        .bits_q    (bits_q),
        .mask_q    (mask_q),
        .stat_clr  (stat_clr),
        .rdata     (bus_rdata)
    );

    modexp_start_edge #(.N(START_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (start_q),
        .pulse (start_pulse)
    );

    modexp_done_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_in   (core_done),
        .clr       (stat_clr),
        .mask_en   (mask_q),
        .done_flag (done_flag),
        .irq       (irq)
    );

    assign core_start       = start_pulse[START_CORE];
    assign dma_start        = start_pulse[START_DMA];
    assign core_run         = start_q[START_CORE];
    assign operand_mode_rsa = (mode_q == MODE_RSA);
    assign exp_bit_len      = bits_q[DATA_W-1 -: HALF_W];
    assign mod_bit_len      = bits_q[HALF_W-1:0];

endmodule

// File: rtl/modexp_ctrl_chk.sv
// Property checker for modexp_ctrl_regs, attached with bind below.
// Assumes done pulses only while the core runs and bus inputs stable at edges.
module modexp_ctrl_chk
    import modexp_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_host_bit,
    input logic              core_done,
    input logic              core_start,
    input logic              dma_start,
    input logic              core_run,
    input logic              operand_host_own,
    input logic              done_flag,
    input logic              irq
);

    // R3
    core_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R3
    dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start);

    // R4
    start_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> core_run);

    // R5
    owner_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_CMD))
        |=> (operand_host_own == $past(wr_host_bit)));

    // R7
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> done_flag);

    // R6
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(core_done));

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);

endmodule

bind modexp_ctrl_regs modexp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_sel          (bus_sel),
    .bus_wr           (bus_wr),
    .bus_addr         (bus_addr),
    .wr_host_bit      (bus_wdata[modexp_ctrl_pkg::CMD_HOST]),
    .core_done        (core_done),
    .core_start       (core_start),
    .dma_start        (dma_start),
    .core_run         (core_run),
    .operand_host_own (operand_host_own),
    .done_flag        (done_flag),
    .irq              (irq)
);

// File: tb/tb_modexp_ctrl_regs.sv
module tb_modexp_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_done;
    logic        dma_start, core_start, core_run;
    logic        operand_mode_rsa, operand_host_own;
    logic [31:0] dma_src_base, dma_byte_len;
    logic [15:0] exp_bit_len, mod_bit_len;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    modexp_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_done(core_done), .dma_start(dma_start), .core_start(core_start),
        .core_run(core_run), .operand_mode_rsa(operand_mode_rsa),
        .operand_host_own(operand_host_own), .dma_src_base(dma_src_base),
        .dma_byte_len(dma_byte_len), .exp_bit_len(exp_bit_len),
        .mod_bit_len(mod_bit_len), .irq(irq)
    );

    // Stub core: done after a programmable delay, only while allowed to run.
    logic [7:0] stub_delay = 8'd5;
    logic [7:0] stub_cnt;
    logic       stub_busy, stub_done;
    logic       force_done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            stub_cnt  <= '0;
            stub_busy <= 1'b0;
            stub_done <= 1'b0;
        end else begin
            stub_done <= 1'b0;
            if (!core_run) begin
                stub_busy <= 1'b0;
            end else if (core_start) begin
                stub_busy <= 1'b1;
                stub_cnt  <= stub_delay;
            end else if (stub_busy) begin
                if (stub_cnt == 0) begin
                    stub_done <= 1'b1;
                    stub_busy <= 1'b0;
                end else begin
                    stub_cnt <= stub_cnt - 8'd1;
                end
            end
        end
    end

    assign core_done = stub_done | force_done;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1", "dma_start", {31'b0, dma_start}, 32'd0);
        chk("R1", "core_start", {31'b0, core_start}, 32'd0);
        chk("R1", "core_run", {31'b0, core_run}, 32'd0);
        chk("R1", "host_own", {31'b0, operand_host_own}, 32'd1);
        chk("R1", "irq", {31'b0, irq}, 32'd0);
        bus_read(12'h000, v); chk("R1", "start reg", v, 32'h0);
        bus_read(12'h048, v); chk("R1", "cmd reg", v, 32'h100);
        bus_read(12'h04C, v); chk("R1", "src reg", v, 32'h0);
        bus_read(12'h050, v); chk("R1", "len reg", v, 32'h0);
        bus_read(12'h058, v); chk("R1", "bits reg", v, 32'h0);
        bus_read(12'h3F8, v); chk("R1", "mask reg", v, 32'h0);
        bus_read(12'h3FC, v); chk("R1", "stat reg", v, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        bus_write(12'h04C, 32'h8000_1234);
        bus_write(12'h050, 32'h0000_1800);
        bus_write(12'h058, 32'h0011_0800);
        bus_read(12'h04C, v); chk("R2", "src readback", v, 32'h8000_1234);
        bus_read(12'h050, v); chk("R2", "len readback", v, 32'h0000_1800);
        bus_read(12'h058, v); chk("R2", "bits readback", v, 32'h0011_0800);
        chk("R2", "src out", dma_src_base, 32'h8000_1234);
        chk("R2", "len out", dma_byte_len, 32'h0000_1800);
        chk("R2", "exp bits", {16'b0, exp_bit_len}, 32'd17);
        chk("R2", "mod bits", {16'b0, mod_bit_len}, 32'd2048);
    endtask

    task automatic t_cmd();
        logic [31:0] v;
        bus_write(12'h048, 32'h0000_0030);
        chk("R5", "rsa mode", {31'b0, operand_mode_rsa}, 32'd1);
        chk("R5", "engine owns", {31'b0, operand_host_own}, 32'd0);
        bus_read(12'h048, v); chk("R5", "cmd readback", v, 32'h30);
        bus_write(12'h048, 32'hFFFF_FFFF);
        bus_read(12'h048, v); chk("R5", "cmd unused bits", v, 32'h130);
        chk("R5", "host owns", {31'b0, operand_host_own}, 32'd1);
        bus_write(12'h048, 32'h0000_0010);
        chk("R5", "mode not rsa", {31'b0, operand_mode_rsa}, 32'd0);
        bus_write(12'h048, 32'h0000_0030);
    endtask

    task automatic t_trigger();
        logic [31:0] v;
        bus_write(12'h000, 32'h3);
        chk("R3", "dma pulse", {31'b0, dma_start}, 32'd1);
        chk("R3", "core pulse", {31'b0, core_start}, 32'd1);
        chk("R4", "run high", {31'b0, core_run}, 32'd1);
        @(negedge clk);
        chk("R3", "dma pulse ends", {31'b0, dma_start}, 32'd0);
        chk("R3", "core pulse ends", {31'b0, core_start}, 32'd0);
        bus_read(12'h000, v); chk("R3", "start readback", v, 32'h3);
        bus_write(12'h000, 32'h3);
        chk("R3", "no repeat dma", {31'b0, dma_start}, 32'd0);
        chk("R3", "no repeat core", {31'b0, core_start}, 32'd0);
        bus_write(12'h000, 32'h0);
        chk("R4", "run stopped", {31'b0, core_run}, 32'd0);
        bus_read(12'h000, v); chk("R4", "start cleared", v, 32'h0);
        bus_write(12'h000, 32'h1);
        chk("R3", "core only", {30'b0, dma_start, core_start}, 32'd1);
        bus_write(12'h000, 32'h3);
        chk("R3", "dma only", {30'b0, dma_start, core_start}, 32'd2);
        bus_write(12'h000, 32'h0);
        repeat (12) @(negedge clk);
        chk("R6", "no done while stopped", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_done_irq();
        logic [31:0] v;
        bus_write(12'h3F8, 32'hFFFF_FFFF);
        bus_read(12'h3F8, v); chk("R8", "mask readback", v, 32'h2);
        bus_write(12'h000, 32'h3);
        for (int i = 0; i < 40 && !irq; i++) @(negedge clk);
        chk("R8", "irq raised", {31'b0, irq}, 32'd1);
        bus_read(12'h3FC, v); chk("R6", "status set", v, 32'h2);
        bus_write(12'h3FC, 32'hFFFF_FFFD);
        bus_read(12'h3FC, v); chk("R6", "status kept", v, 32'h2);
        bus_write(12'h3FC, 32'h2);
        bus_read(12'h3FC, v); chk("R6", "status cleared", v, 32'h0);
        chk("R8", "irq dropped", {31'b0, irq}, 32'd0);
        bus_write(12'h000, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        bus_write(12'h3F8, 32'h0);
        @(negedge clk); force_done = 1'b1;
        @(negedge clk); force_done = 1'b0;
        bus_read(12'h3FC, v); chk("R8", "status while masked", v, 32'h2);
        chk("R8", "irq masked", {31'b0, irq}, 32'd0);
        bus_write(12'h3F8, 32'h2);
        chk("R8", "irq unmasked", {31'b0, irq}, 32'd1);
        bus_write(12'h3FC, 32'h2);
        chk("R8", "irq after clear", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h3FC; bus_wdata = 32'h2;
        force_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; force_done = 1'b0;
        bus_read(12'h3FC, v); chk("R7", "set beats clear", v, 32'h2);
        bus_write(12'h3FC, 32'h2);
        bus_read(12'h3FC, v); chk("R7", "later clear", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_read(12'h004, v); chk("R9", "read 0x004", v, 32'h0);
        bus_read(12'h054, v); chk("R9", "read 0x054", v, 32'h0);
        bus_read(12'h3F4, v); chk("R9", "read 0x3F4", v, 32'h0);
        bus_write(12'h054, 32'hFFFF_FFFF);
        bus_write(12'h100, 32'hFFFF_FFFF);
        bus_write(12'h3F0, 32'hFFFF_FFFF);
        bus_read(12'h000, v); chk("R9", "start untouched", v, 32'h0);
        bus_read(12'h048, v); chk("R9", "cmd untouched", v, 32'h30);
        bus_read(12'h04C, v); chk("R9", "src untouched", v, 32'h8000_1234);
        bus_read(12'h050, v); chk("R9", "len untouched", v, 32'h0000_1800);
        bus_read(12'h058, v); chk("R9", "bits untouched", v, 32'h0011_0800);
        bus_read(12'h3F8, v); chk("R9", "mask untouched", v, 32'h2);
        bus_read(12'h3FC, v); chk("R9", "stat untouched", v, 32'h0);
        chk("R9", "irq quiet", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_cmd();
        t_trigger();
        t_done_irq();
        t_mask();
        t_race();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule